// File: doc/BRIEF.md
# In-Page Conditional Branch Unit

This block decides the outcome of a short conditional branch and produces the program counter that execution continues from. It sees a four-bit condition code, the eight-bit accumulator, the carry flag, four active-low external flag pins, the address of the branch's immediate byte, and that byte itself. A taken branch keeps the page (the upper address byte) of the immediate byte and replaces the low byte with the immediate value, so the destination always stays inside that 256-byte page. A branch that is not taken moves the counter one step past the immediate byte, so the next fetch follows it.

The sequencer pulses `req_valid` for one cycle with all operands stable; one cycle later the registered verdict and next program counter appear together with a single-cycle `out_valid`. The external flag pins are treated as asynchronous and pass through a two-stage synchronizer before any condition reads them.

Top module: `inpage_branch_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0, `out_taken` is 0 and `out_pc` is 16'h0000.
- R2: `out_valid` is high in exactly those cycles that directly follow a rising edge at which `req_valid` was 1; back-to-back requests give back-to-back results.
- R3: For a taken branch, `out_pc[15:8]` equals `pc_in[15:8]` and `out_pc[7:0]` equals `imm_byte`, as captured with the request.
- R4: For a branch not taken, `out_pc` equals `pc_in + 1` modulo 2^16; an immediate byte at low-byte offset 8'hFF continues in the next page, and 16'hFFFF wraps to 16'h0000.
- R5: `cond_code[3]` inverts the condition picked by `cond_code[2:0]`. Select 0 is always true, so code 4'h0 always branches and 4'h8 never does; select 7 is always false, so 4'h7 never branches and 4'hF always does.
- R6: Select 1 is true when `d_acc` is 8'h00: code 4'h1 branches on a zero accumulator and code 4'h9 on a non-zero one.
- R7: Select 2 is true when `df_flag` is 1: code 4'h2 branches when the carry flag is set and code 4'hA when it is clear.
- R8: Selects 3, 4, 5 and 6 are true when flag pin `ef_n[0]`, `ef_n[1]`, `ef_n[2]` and `ef_n[3]` respectively reads low; codes 4'hB to 4'hE branch when that pin reads high.
- R9: A level change on an `ef_n` pin, made between clock edges, is seen by a request captured at the third rising edge after the change and not by one captured at the second.
- R10: In cycles without a result, `out_pc` and `out_taken` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request; operands below are sampled with it |
| cond_code | input | 4 | Condition: bit 3 inverts, bits 2:0 select the test |
| d_acc | input | 8 | Accumulator value tested by select 1 |
| df_flag | input | 1 | Carry flag tested by select 2 |
| ef_n | input | 4 | Asynchronous active-low external flags, bit 0 is flag 1 |
| pc_in | input | 16 | Address of the immediate byte |
| imm_byte | input | 8 | Immediate byte: low byte of the branch target |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| out_taken | output | 1 | 1 when the branch was taken |
| out_pc | output | 16 | Next program counter |

## Verification
The bench pushes the immediate byte to low-byte offset 8'hFF in both outcomes: a unit that took the page from the incremented counter would land a taken branch one page too high, and a unit that only incremented the low byte would wrap a not-taken branch back into the same page; the 16'hFFFF case catches a carry that escapes the counter width. Every condition code is run in both senses with the tested operand on either side, so a swapped inversion, an accumulator test off by a bit, or a flag wired to the wrong select shows up as a wrong verdict. A flag edge is timed against the second and third capture edges, which exposes a synchronizer that is one stage short or one stage long, and an idle gap after a result shows whether the output registers drift between requests.

// File: rtl/pgbr_pkg.sv
package pgbr_pkg;

  localparam int PC_W      = 16;
  localparam int IMM_W     = 8;
  localparam int ACC_W     = 8;
  localparam int FLAG_N    = 4;
  localparam int SEL_W     = 3;
  localparam int COND_W    = SEL_W + 1;
  localparam int PAGE_W    = PC_W - IMM_W;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALWAYS = 3'd0,
    SEL_DZERO  = 3'd1,
    SEL_CARRY  = 3'd2,
    SEL_FLAG1  = 3'd3,
    SEL_FLAG2  = 3'd4,
    SEL_FLAG3  = 3'd5,
    SEL_FLAG4  = 3'd6,
    SEL_NONE   = 3'd7
  } test_sel_e;

  typedef struct packed {
    logic      invert;
    test_sel_e sel;
  } cond_t;

  function automatic cond_t split_cond(input logic [COND_W-1:0] code);
    cond_t c;
    c.invert = code[COND_W-1];
    c.sel    = test_sel_e'(code[SEL_W-1:0]);
    return c;
  endfunction

  function automatic logic [PC_W-1:0] page_target(input logic [PC_W-1:0] imm_addr,
                                                   input logic [IMM_W-1:0] imm);
    return {imm_addr[PC_W-1:IMM_W], imm};
  endfunction

  function automatic logic [PC_W-1:0] step_past(input logic [PC_W-1:0] imm_addr);
    return imm_addr + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/pgbr_flag_sync.sv
module pgbr_flag_sync
  import pgbr_pkg::*;
#(
  parameter int WIDTH  = FLAG_N,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] active
);

  localparam int LAST = STAGES - 1;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain <= '1;
        end else begin
          chain <= {chain[STAGES-2:0], pin_n[g]};
        end
      end
      assign active[g] = ~chain[LAST];
    end
  endgenerate

endmodule

// File: rtl/pgbr_cond_eval.sv
module pgbr_cond_eval
  import pgbr_pkg::*;
(
  input  logic [COND_W-1:0] cond_code,
  input  logic [ACC_W-1:0]  d_acc,
  input  logic              df_flag,
  input  logic [FLAG_N-1:0] flag_active,
  output logic              raw_true,
  output logic              taken
);

  cond_t c;
  logic  acc_zero;

  assign c        = split_cond(cond_code);
  assign acc_zero = (d_acc == '0);

  always_comb begin
    unique case (c.sel)
      SEL_ALWAYS: raw_true = 1'b1;
      SEL_DZERO:  raw_true = acc_zero;
      SEL_CARRY:  raw_true = df_flag;
      SEL_FLAG1:  raw_true = flag_active[0];
      SEL_FLAG2:  raw_true = flag_active[1];
      SEL_FLAG3:  raw_true = flag_active[2];
      SEL_FLAG4:  raw_true = flag_active[3];
      default:    raw_true = 1'b0;
    endcase
  end

  assign taken = raw_true ^ c.invert;

endmodule

// File: rtl/pgbr_pc_calc.sv
module pgbr_pc_calc
  import pgbr_pkg::*;
(
  input  logic [PC_W-1:0]  imm_addr,
  input  logic [IMM_W-1:0] imm,
  input  logic             taken,
  output logic [PC_W-1:0]  target_pc,
  output logic [PC_W-1:0]  fall_pc,
  output logic [PC_W-1:0]  next_pc
);

  assign target_pc = page_target(imm_addr, imm);
  assign fall_pc   = step_past(imm_addr);
  assign next_pc   = taken ? target_pc : fall_pc;

endmodule

// File: rtl/inpage_branch_unit.sv
module inpage_branch_unit
  import pgbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [COND_W-1:0] cond_code,
  input  logic [ACC_W-1:0]  d_acc,
  input  logic              df_flag,
  input  logic [FLAG_N-1:0] ef_n,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [IMM_W-1:0]  imm_byte,
  output logic              out_valid,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_pc
);

  logic [FLAG_N-1:0] ef_active;
  logic              cond_raw;
  logic              taken_w;
  logic [PC_W-1:0]   target_w;
  logic [PC_W-1:0]   fall_w;
  logic [PC_W-1:0]   next_w;

  pgbr_flag_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (ef_n),
    .active (ef_active)
  );

  pgbr_cond_eval u_eval (
    .cond_code   (cond_code),
    .d_acc       (d_acc),
    .df_flag     (df_flag),
    .flag_active (ef_active),
    .raw_true    (cond_raw),
    .taken       (taken_w)
  );

  pgbr_pc_calc u_pc (
    .imm_addr  (pc_in),
    .imm       (imm_byte),
    .taken     (taken_w),
    .target_pc (target_w),
    .fall_pc   (fall_w),
    .next_pc   (next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_pc    <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_taken <= taken_w;
        out_pc    <= next_w;
      end
    end
  end

endmodule

// File: rtl/pgbr_checker.sv
module pgbr_checker
  import pgbr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [COND_W-1:0] cond_code,
  input logic [PC_W-1:0]   pc_in,
  input logic [IMM_W-1:0]  imm_byte,
  input logic [FLAG_N-1:0] ef_n,
  input logic [FLAG_N-1:0] ef_active,
  input logic              out_valid,
  input logic              out_taken,
  input logic [PC_W-1:0]   out_pc
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_taken && out_pc == '0)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |-> (out_valid == $past(req_valid))); // R2

  AST_TAKEN_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && out_valid && out_taken) |->
      (out_pc == {$past(pc_in[PC_W-1:IMM_W]), $past(imm_byte)})); // R3

  AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && out_valid && !out_taken) |->
      (out_pc == PC_W'($past(pc_in) + 1))); // R4

  AST_CODE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (cond_code == 4'h0 || cond_code == 4'hF)) |=> out_taken); // R5

  AST_CODE_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (cond_code == 4'h8 || cond_code == 4'h7)) |=> !out_taken); // R5

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (ef_active == ~$past(ef_n, 2))); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> ($stable(out_pc) && $stable(out_taken))); // R10

endmodule

bind inpage_branch_unit pgbr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .cond_code (cond_code),
  .pc_in     (pc_in),
  .imm_byte  (imm_byte),
  .ef_n      (ef_n),
  .ef_active (ef_active),
  .out_valid (out_valid),
  .out_taken (out_taken),
  .out_pc    (out_pc)
);

// File: tb/inpage_branch_unit_test.sv
module inpage_branch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  cond_code = '0;
  logic [7:0]  d_acc = '0;
  logic        df_flag = 1'b0;
  logic [3:0]  ef_n = 4'hF;
  logic [15:0] pc_in = '0;
  logic [7:0]  imm_byte = '0;
  logic        out_valid;
  logic        out_taken;
  logic [15:0] out_pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  inpage_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cond_code(cond_code),
    .d_acc(d_acc), .df_flag(df_flag), .ef_n(ef_n), .pc_in(pc_in),
    .imm_byte(imm_byte), .out_valid(out_valid), .out_taken(out_taken), .out_pc(out_pc)
  );

  // Reference model written from the requirements
  function automatic bit ref_taken(input logic [3:0] cc, input logic [7:0] d,
                                   input logic df, input logic [3:0] efn);
    bit t;
    case (cc[2:0])
      3'd0: t = 1;
      3'd1: t = (d == 8'd0);
      3'd2: t = df;
      3'd3, 3'd4, 3'd5, 3'd6: t = !efn[cc[2:0] - 3'd3];
      default: t = 0;
    endcase
    return t != cc[3];
  endfunction

  function automatic logic [15:0] ref_pc(input bit t, input logic [15:0] pc,
                                         input logic [7:0] imm);
    logic [16:0] inc;
    inc = {1'b0, pc} + 17'd1;
    return t ? {pc[15:8], imm} : inc[15:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, result is checked at the following falling edge
  task automatic request(input string tag, input logic [3:0] cc, input logic [7:0] d,
                         input logic df, input logic [15:0] pc, input logic [7:0] imm);
    bit t;
    t = ref_taken(cc, d, df, ef_n);
    cond_code = cc; d_acc = d; df_flag = df; pc_in = pc; imm_byte = imm;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check({tag, " taken"}, 32'(out_taken), 32'(t));
    check({tag, " pc"}, 32'(out_pc), 32'(ref_pc(t, pc, imm)));
  endtask

  task automatic set_flags(input logic [3:0] v);
    ef_n = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] held_pc;
    logic        held_tk;
    void'($urandom(32'h1D2C_3B4A));
    repeat (4) @(negedge clk);
    // R1: reset values
    check("R1 valid", 32'(out_valid), 0);
    check("R1 taken", 32'(out_taken), 0);
    check("R1 pc", 32'(out_pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(out_valid), 0);
    set_flags(4'hF);

    // R5: always / never, including select 7
    request("R5 code0", 4'h0, 8'h55, 0, 16'h3410, 8'h22);
    request("R5 code8", 4'h8, 8'h55, 0, 16'h3410, 8'h22);
    request("R5 code7", 4'h7, 8'h00, 1, 16'h0102, 8'h99);
    request("R5 codeF", 4'hF, 8'h00, 1, 16'h0102, 8'h99);
    // R6: accumulator tests
    request("R6 code1 zero", 4'h1, 8'h00, 0, 16'h2200, 8'h40);
    request("R6 code1 nz", 4'h1, 8'h80, 0, 16'h2200, 8'h40);
    request("R6 code9 zero", 4'h9, 8'h00, 0, 16'h2200, 8'h40);
    request("R6 code9 nz", 4'h9, 8'h01, 0, 16'h2200, 8'h40);
    // R7: carry tests
    request("R7 code2 set", 4'h2, 8'h11, 1, 16'h7730, 8'h05);
    request("R7 code2 clr", 4'h2, 8'h11, 0, 16'h7730, 8'h05);
    request("R7 codeA set", 4'hA, 8'h11, 1, 16'h7730, 8'h05);
    request("R7 codeA clr", 4'hA, 8'h11, 0, 16'h7730, 8'h05);
    // R8: each flag, one pin low at a time, both senses
    for (int k = 0; k < 4; k++) begin
      set_flags(~(4'b1 << k));
      for (int s = 3; s <= 6; s++) begin
        request("R8 pos", 4'(s), 8'h3C, 0, 16'h5A00 + 16'(s), 8'hC3);
        request("R8 neg", 4'(s + 8), 8'h3C, 0, 16'h5A00 + 16'(s), 8'hC3);
      end
    end
    set_flags(4'hF);

    // R3/R4: page boundary at offset FF
    request("R3 taken at FF", 4'h0, 8'h00, 0, 16'h12FF, 8'h34);
    request("R4 fall at FF", 4'h8, 8'h00, 0, 16'h12FF, 8'h34);
    request("R4 wrap FFFF", 4'h8, 8'h00, 0, 16'hFFFF, 8'h00);
    request("R3 top page", 4'h0, 8'h00, 0, 16'hFFFF, 8'h7E);

    // R2 and R10: back-to-back, then idle hold
    request("R2 first", 4'h1, 8'h00, 0, 16'h4000, 8'h10);
    request("R2 second", 4'h9, 8'h00, 0, 16'h4001, 8'h10);
    held_pc = out_pc; held_tk = out_taken;
    cond_code = 4'h0; pc_in = 16'hBEEF; imm_byte = 8'hAA;
    repeat (3) begin
      @(negedge clk);
      check("R2 idle valid low", 32'(out_valid), 0);
      check("R10 pc held", 32'(out_pc), 32'(held_pc));
      check("R10 taken held", 32'(out_taken), 32'(held_tk));
    end

    // R9: flag edge seen at the third capture edge, not the second
    ef_n = 4'b1110;
    @(negedge clk);
    cond_code = 4'h3; pc_in = 16'h6060; imm_byte = 8'h01; req_valid = 1'b1;
    @(negedge clk);
    check("R9 second edge old level", 32'(out_taken), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 third edge new level", 32'(out_taken), 1);
    check("R9 pc", 32'(out_pc), 32'h6001);
    set_flags(4'hF);

    // Random mix (R3 R4 R5 R6 R7 R8)
    for (int b = 0; b < 40; b++) begin
      set_flags(4'($urandom));
      for (int i = 0; i < 20; i++) begin
        logic [15:0] p;
        logic [7:0]  d;
        p = 16'($urandom);
        if ($urandom_range(0, 3) == 0) p[7:0] = 8'hFF;
        d = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
        request("R3/R4 random", 4'($urandom), d, 1'($urandom), p, 8'($urandom));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule